// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block sequences the two gate enables of one half-bridge phase when the high-side and low-side switches each have their own command input. A command asks for its gate to turn on. Before that gate is enabled, the opposite gate is commanded off. Its discharge is then watched through a below-threshold comparator flag, and a dead interval follows. The dead interval has a programmable fixed count, and it is stretched for as long as the off-going gate is not seen below threshold.

Each drive phase is bounded by a programmable timeout. A turn-on phase ends when the gate reports fully charged, and a turn-off phase ends when the gate reports below threshold. A phase also ends if the command changes. If the timeout runs out first, a sticky fault forces both gates off until software clears it. The block runs on a single tick clock, and one clock period is the sampling interval of the commands.

Both the timeout and the fixed dead count are given in ticks. Each is captured when a phase begins.

Top module: `halfbridge_gate_seq`

## Requirements
- R1: While `rst` is high at a rising edge, `gate_hi`, `gate_lo` and `fault` are 0 after that edge.
- R2: The commands are registered once. From idle with both gates discharged, a high-side request raises `gate_hi` on edge number `dead_fixed`+4, where edge 1 is the first edge that sees the command.
- R3: `gate_hi` and `gate_lo` are never 1 together. When both commands are high (encoding {cmd_hi,cmd_lo}=2'b11), an enabled gate turns off on edge 2 and both stay off with no fault.
- R4: On a change of request from one side to the other, the on gate drops on edge 2. The other gate rises only after the off-going gate is flagged below threshold and then `dead_fixed`+1 more edges have passed. For a gate that needs D ticks to fall below threshold, this is edge D+`dead_fixed`+4.
- R5: If the off-going gate's below-threshold flag drops during the dead interval, the new gate stays off until the flag returns. The new gate then rises on the next edge once the fixed count is spent.
- R6: A command that is high for a single tick from idle gives exactly one tick of gate enable.
- R7: A turn-on phase ends when the gate reports fully charged, so a gate that charges within the timeout raises no fault.
- R8: A phase without the expected feedback within `drive_limit`+1 ticks of its start raises `fault`. On that same edge both gates go off. `fault` stays set until a cycle with `fault_clr` high clears it.
- R9: `drive_limit` and `dead_fixed` are captured when a phase begins. Changing them mid-phase does not alter the phase in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, one sampling interval per period |
| rst | input | 1 | Synchronous active-high reset |
| cmd_hi | input | 1 | High-side on command |
| cmd_lo | input | 1 | Low-side on command |
| hi_full | input | 1 | High-side gate fully charged |
| hi_below | input | 1 | High-side gate below threshold |
| lo_full | input | 1 | Low-side gate fully charged |
| lo_below | input | 1 | Low-side gate below threshold |
| drive_limit | input | CNT_W | Drive-phase timeout in ticks |
| dead_fixed | input | CNT_W | Fixed dead interval in ticks |
| fault_clr | input | 1 | Clears the sticky fault |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |
| fault | output | 1 | Sticky gate-drive fault |

## Verification
The bench models each gate as a charge counter and sets exact edge counts for a request from idle and for a side-to-side switch. These counts separate a missing discharge wait from a missing fixed dead interval. A one-tick pulse tells a sequencer that keeps a short request from one that drops it. A dual-high command shows that conflict is treated as a request for neither gate. Masking the below-threshold flag during the dead interval exposes the variable part, and masking the full flag forces a timeout. A timeout register changed mid-phase then shows whether the value was captured at phase start.

// File: rtl/gds_pkg.sv
package gds_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_DEAD,
    S_TON,
    S_ON,
    S_REL,
    S_FAULT
  } gds_state_t;

  // Encoding is {high command, low command}
  typedef enum logic [1:0] {
    T_NONE = 2'b00,
    T_LO   = 2'b01,
    T_HI   = 2'b10,
    T_BOTH = 2'b11
  } gds_tgt_t;

endpackage

// File: rtl/gds_sampler.sv
module gds_sampler
  import gds_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cmd_hi,
  input  logic     cmd_lo,
  output gds_tgt_t tgt
);

  always_ff @(posedge clk) begin
    if (rst) tgt <= T_NONE;
    else     tgt <= gds_tgt_t'({cmd_hi, cmd_lo});
  end

endmodule

// File: rtl/gds_timer.sv
module gds_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/gds_fsm.sv
module gds_fsm
  import gds_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  gds_tgt_t     tgt,
  input  logic         hi_full,
  input  logic         hi_below,
  input  logic         lo_full,
  input  logic         lo_below,
  input  logic [W-1:0] drive_limit,
  input  logic [W-1:0] dead_fixed,
  input  logic         fault_clr,
  input  logic         timer_zero,
  output logic         load,
  output logic [W-1:0] load_val,
  output logic         gate_hi,
  output logic         gate_lo,
  output logic         fault
);

  gds_state_t state, nxt;
  logic       act, nact;   // side this state concerns: 1 high, 0 low

  logic want_act, want_opp, own_below, opp_below, own_full;

  always_comb begin
    want_act  = act ? (tgt == T_HI) : (tgt == T_LO);
    want_opp  = act ? (tgt == T_LO) : (tgt == T_HI);
    own_below = act ? hi_below : lo_below;
    opp_below = act ? lo_below : hi_below;
    own_full  = act ? hi_full  : lo_full;
  end

  always_comb begin
    nxt  = state;
    nact = act;
    unique case (state)
      S_IDLE: begin
        if (tgt == T_HI || tgt == T_LO) begin
          nxt  = S_PRE;
          nact = (tgt == T_HI);
        end
      end
      S_PRE: begin
        if (tgt == T_BOTH)   nxt = S_IDLE;
        else if (want_opp)   nact = !act;
        else if (opp_below)  nxt = S_DEAD;
        else if (timer_zero) nxt = S_FAULT;
      end
      S_DEAD: begin
        if (tgt == T_BOTH) nxt = S_IDLE;
        else if (want_opp) begin
          nxt  = S_PRE;
          nact = !act;
        end
        else if (timer_zero && opp_below) nxt = S_TON;
      end
      S_TON: begin
        if (!want_act)       nxt = S_REL;
        else if (own_full)   nxt = S_ON;
        else if (timer_zero) nxt = S_FAULT;
      end
      S_ON: begin
        if (!want_act) nxt = S_REL;
      end
      S_REL: begin
        if (want_act) nxt = S_TON;
        else if (own_below) begin
          if (want_opp) begin
            nxt  = S_DEAD;
            nact = !act;
          end else begin
            nxt = S_IDLE;
          end
        end
        else if (timer_zero) nxt = S_FAULT;
      end
      S_FAULT: begin
        if (fault_clr) nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign load     = (nxt != state) || (nact != act);
  assign load_val = (nxt == S_DEAD) ? dead_fixed : drive_limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      act     <= 1'b0;
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
      fault   <= 1'b0;
    end else begin
      state   <= nxt;
      act     <= nact;
      gate_hi <= (nxt == S_TON || nxt == S_ON) &&  nact;
      gate_lo <= (nxt == S_TON || nxt == S_ON) && !nact;
      fault   <= (nxt == S_FAULT);
    end
  end

endmodule

// File: rtl/halfbridge_gate_seq.sv
module halfbridge_gate_seq
  import gds_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_hi,
  input  logic             cmd_lo,
  input  logic             hi_full,
  input  logic             hi_below,
  input  logic             lo_full,
  input  logic             lo_below,
  input  logic [CNT_W-1:0] drive_limit,
  input  logic [CNT_W-1:0] dead_fixed,
  input  logic             fault_clr,
  output logic             gate_hi,
  output logic             gate_lo,
  output logic             fault
);

  gds_tgt_t         tgt;
  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_zero;

  gds_sampler u_sampler (
    .clk    (clk),
    .rst    (rst),
    .cmd_hi (cmd_hi),
    .cmd_lo (cmd_lo),
    .tgt    (tgt)
  );

  gds_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  gds_fsm #(.W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .tgt         (tgt),
    .hi_full     (hi_full),
    .hi_below    (hi_below),
    .lo_full     (lo_full),
    .lo_below    (lo_below),
    .drive_limit (drive_limit),
    .dead_fixed  (dead_fixed),
    .fault_clr   (fault_clr),
    .timer_zero  (t_zero),
    .load        (t_load),
    .load_val    (t_val),
    .gate_hi     (gate_hi),
    .gate_lo     (gate_lo),
    .fault       (fault)
  );

endmodule

// File: rtl/gds_checker.sv
module gds_checker (
  input logic clk,
  input logic rst,
  input logic gate_hi,
  input logic gate_lo,
  input logic fault,
  input logic fault_clr,
  input logic hi_below,
  input logic lo_below
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!gate_hi && !gate_lo && !fault));

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
    !(gate_hi && gate_lo));

  assert_hi_on_needs_lo_below_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_hi) |-> lo_below);

  assert_lo_on_needs_hi_below_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_lo) |-> hi_below);

  assert_gap_after_lo_off_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_lo) |=> !gate_hi);

  assert_fault_gates_off_R8: assert property (@(posedge clk) disable iff (rst)
    fault |-> (!gate_hi && !gate_lo));

  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (fault && !fault_clr) |=> fault);

endmodule

bind halfbridge_gate_seq gds_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .gate_hi   (gate_hi),
  .gate_lo   (gate_lo),
  .fault     (fault),
  .fault_clr (fault_clr),
  .hi_below  (hi_below),
  .lo_below  (lo_below)
);

// File: tb/halfbridge_gate_seq_tb.sv
module halfbridge_gate_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int FULL       = 8;   // model charge level reported as full
  localparam int TH         = 3;   // model level below which gate is "below"
  localparam int D_FALL     = FULL - TH + 1;
  localparam int LIMIT      = 12;
  localparam int DEAD       = 3;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_hi = 1'b0, cmd_lo = 1'b0, fault_clr = 1'b0;
  logic [CNT_W-1:0] drive_limit = CNT_W'(LIMIT);
  logic [CNT_W-1:0] dead_fixed  = CNT_W'(DEAD);
  logic hi_full, hi_below, lo_full, lo_below;
  logic gate_hi, gate_lo, fault;
  logic mask_hi_below = 1'b0, mask_hi_full = 1'b0;
  logic [3:0] chg_hi, chg_lo;

  int nchecks = 0;
  int nfail   = 0;
  int overlaps = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halfbridge_gate_seq #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
    .hi_full(hi_full), .hi_below(hi_below), .lo_full(lo_full), .lo_below(lo_below),
    .drive_limit(drive_limit), .dead_fixed(dead_fixed), .fault_clr(fault_clr),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .fault(fault)
  );

  // Gate model: charge climbs one step per tick while enabled, falls otherwise
  always @(posedge clk) begin
    if (rst) begin
      chg_hi <= '0;
      chg_lo <= '0;
    end else begin
      chg_hi <= gate_hi ? ((chg_hi == 4'(FULL)) ? chg_hi : chg_hi + 1'b1)
                        : ((chg_hi == 4'd0) ? chg_hi : chg_hi - 1'b1);
      chg_lo <= gate_lo ? ((chg_lo == 4'(FULL)) ? chg_lo : chg_lo + 1'b1)
                        : ((chg_lo == 4'd0) ? chg_lo : chg_lo - 1'b1);
    end
  end

  assign hi_full  = (chg_hi == 4'(FULL)) && !mask_hi_full;
  assign hi_below = (chg_hi < 4'(TH)) && !mask_hi_below;
  assign lo_full  = (chg_lo == 4'(FULL));
  assign lo_below = (chg_lo < 4'(TH));

  always @(negedge clk) if (!rst && gate_hi && gate_lo) overlaps++;

  task automatic chk(input string req, input int actual, input int expected);
    nchecks++;
    if (actual != expected) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic logic probe(input int sel);
    return (sel == 0) ? gate_lo : (sel == 1) ? gate_hi : fault;
  endfunction

  // Counts rising edges until the probed output reaches the level
  task automatic wait_for(input int sel, input logic level, input int maxn, output int n);
    n = 0;
    do begin
      @(posedge clk); @(negedge clk);
      n++;
    end while (probe(sel) != level && n < maxn);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 gate_hi in reset", int'(gate_hi), 0);
    chk("R1 gate_lo in reset", int'(gate_lo), 0);
    chk("R1 fault in reset", int'(fault), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_idle_to_hi;
    int n;
    cmd_hi = 1'b1;
    wait_for(1, 1'b1, 60, n);
    chk("R2 idle request latency", n, DEAD + 4);
    chk("R2 low gate stays off", int'(gate_lo), 0);
    repeat (LIMIT + 3) @(negedge clk);
    chk("R7 no fault after full charge", int'(fault), 0);
  endtask

  task automatic t_switch_to_lo;
    int n;
    cmd_hi = 1'b0; cmd_lo = 1'b1;
    wait_for(1, 1'b0, 20, n);
    chk("R4 high gate release edge", n, 2);
    wait_for(0, 1'b1, 60, n);
    chk("R4 low gate rise after discharge and dead", n, D_FALL + DEAD + 2);
    repeat (LIMIT + 3) @(negedge clk);
  endtask

  task automatic t_both_high;
    int n;
    cmd_hi = 1'b1;
    wait_for(0, 1'b0, 20, n);
    chk("R3 dual command drops gate", n, 2);
    repeat (20) @(negedge clk);
    chk("R3 dual command both off", int'(gate_hi | gate_lo), 0);
    chk("R3 dual command no fault", int'(fault), 0);
    cmd_hi = 1'b0; cmd_lo = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_min_pulse;
    int n;
    cmd_hi = 1'b1;
    @(negedge clk);
    cmd_hi = 1'b0;
    wait_for(1, 1'b1, 60, n);
    chk("R6 single tick pulse reaches gate", n, DEAD + 3);
    wait_for(1, 1'b0, 20, n);
    chk("R6 single tick pulse width", n, 1);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_variable_dead;
    int n;
    cmd_hi = 1'b1;
    repeat (DEAD + 4 + FULL + 8) @(negedge clk);
    cmd_hi = 1'b0; cmd_lo = 1'b1;
    wait_for(1, 1'b0, 20, n);
    chk("R5 high gate release edge", n, 2);
    repeat (D_FALL + 1) @(negedge clk);
    mask_hi_below = 1'b1;
    repeat (12) @(negedge clk);
    chk("R5 low gate held while flag lost", int'(gate_lo), 0);
    mask_hi_below = 1'b0;
    wait_for(0, 1'b1, 20, n);
    chk("R5 low gate rises once flag returns", n, 1);
    cmd_lo = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_timeout;
    int n;
    mask_hi_full = 1'b1;
    cmd_hi = 1'b1;
    wait_for(1, 1'b1, 60, n);
    chk("R8 request reaches gate", n, DEAD + 4);
    repeat (3) @(negedge clk);
    drive_limit = CNT_W'(40);
    wait_for(2, 1'b1, 80, n);
    chk("R9 timeout uses value captured at phase start", n, LIMIT + 1 - 3);
    chk("R8 gates off on fault", int'(gate_hi | gate_lo), 0);
    cmd_hi = 1'b0; mask_hi_full = 1'b0;
    drive_limit = CNT_W'(LIMIT);
    repeat (10) @(negedge clk);
    chk("R8 fault is sticky", int'(fault), 1);
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
    chk("R8 fault cleared", int'(fault), 0);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_idle_to_hi();
    t_switch_to_lo();
    t_both_high();
    t_min_pulse();
    t_variable_dead();
    t_timeout();
    chk("R3 no overlap seen", overlaps, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R1..all actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

endmodule